// File: doc/BRIEF.md
# Page Address Extender with Key Protection

This block widens a 16-bit logical word address into a 20-bit physical word address. The processor puts the logical address on a shared address/data bus and marks it with an address strobe. The block captures the address, along with the group select, the access key and the memory/I-O flag, when the strobe goes from high to low. It then keeps that snapshot until the next strobe, so the bus is free to carry data.

The four group-select inputs pick one of sixteen groups of page entries. The top nibble of the captured address picks one of the sixteen entries in that group. Each entry holds an 8-bit physical page number and a 4-bit lock. On a memory cycle, the physical address is the page number with the 12-bit in-page offset appended, and the captured key is compared with the entry's lock. A difference raises the protection error. On an I/O cycle, the logical address passes through zero-extended and the error stays low. A write port loads single entries. The lookup reads the table live, so a write to the entry in use changes the held outputs.

Top module: `page_xlate_guard`

## Requirements
- R1: While reset is low, and after it until the first strobe, phys_addr_o and phys_page_o are zero and prot_err_o is low. Reset loads every entry with page number equal to its entry index and lock 0, so in every group a memory address maps to itself.
- R2: The block captures addr_data_i, grp_sel_i, key_i and mem_cycle_i on the first rising clock edge at which addr_stb_i is sampled low after being sampled high on the edge before. The outputs reflect the new snapshot from the cycle after that edge. Any other change on those inputs has no effect.
- R3: addr_data_i bit 0 is the most significant bit. Bits 0..3 form the entry index, with bit 0 as its MSB. Bits 4..15 form the offset, and they appear unchanged on phys_addr_o[11:0].
- R4: The captured grp_sel_i value chooses which group of entries is looked up.
- R5: On a memory cycle (mem_cycle_i high), phys_addr_o is {entry page, offset} and phys_page_o is the entry page.
- R6: On an I/O cycle (mem_cycle_i low), phys_addr_o is {4'b0000, logical address}, phys_page_o is phys_addr_o[19:12], and prot_err_o is low.
- R7: On a memory cycle, prot_err_o is high exactly when the captured key differs from the selected entry's lock.
- R8: When wr_en_i is high at a rising edge, the block stores wr_page_i and wr_lock_i into entry wr_idx_i of group wr_grp_i. The outputs use the new contents from the next cycle, including for a snapshot already held.
- R9: Between strobes, with no write, phys_addr_o, phys_page_o and prot_err_o stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| addr_data_i | input | 16 | Multiplexed address/data bus, bit 0 most significant |
| addr_stb_i | input | 1 | Address strobe, active high, captured on its fall |
| grp_sel_i | input | 4 | Page group select |
| key_i | input | 4 | Access key |
| mem_cycle_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| wr_en_i | input | 1 | Entry write enable |
| wr_grp_i | input | 4 | Group of the entry to write |
| wr_idx_i | input | 4 | Index of the entry to write |
| wr_page_i | input | 8 | Physical page number to store |
| wr_lock_i | input | 4 | Lock value to store |
| phys_page_o | output | 8 | Upper 8 bits of the physical address |
| phys_addr_o | output | 20 | Physical word address |
| prot_err_o | output | 1 | Key/lock mismatch on a memory cycle |

## Verification
The assertions assume that all inputs are known values at every sampled edge. They also assume that one sampled high-then-low pair on the strobe marks exactly one capture, with no glitch inside a cycle. The hold property excludes cycles with a write, because a write may legally change a held result. The stimulus drives every input only on falling clock edges and keeps the strobe high for at least one full cycle before dropping it. It issues writes only as single-cycle pulses, so each capture and each write lands on one known edge.

// File: rtl/pxg_pkg.sv
package pxg_pkg;
    parameter int ADDR_W = 16;
    parameter int GSEL_W = 4;
    parameter int IDX_W  = 4;
    parameter int PAGE_W = 8;
    parameter int LOCK_W = 4;

    localparam int OFF_W   = ADDR_W - IDX_W;
    localparam int PHYS_W  = PAGE_W + OFF_W;
    localparam int N_GRP   = 1 << GSEL_W;
    localparam int N_ENT   = 1 << IDX_W;
    localparam int EXT_W   = PHYS_W - ADDR_W;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [LOCK_W-1:0] lock;
    } pte_t;

    typedef struct packed {
        logic              stb_prev;
        logic              valid;
        logic              mem;
        logic [GSEL_W-1:0] grp;
        logic [LOCK_W-1:0] key;
        logic [ADDR_W-1:0] addr;
    } snap_t;
endpackage

// File: rtl/pxg_capture.sv
module pxg_capture
    import pxg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stb_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [GSEL_W-1:0] grp_i,
    input  logic [LOCK_W-1:0] key_i,
    input  logic              mem_i,
    output snap_t             snap_o
);
    snap_t snap_d, snap_q;

    always_comb begin
        snap_d          = snap_q;
        snap_d.stb_prev = stb_i;
        if (snap_q.stb_prev && !stb_i) begin
            snap_d.valid = 1'b1;
            snap_d.addr  = addr_i;
            snap_d.grp   = grp_i;
            snap_d.key   = key_i;
            snap_d.mem   = mem_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) snap_q <= '0;
        else         snap_q <= snap_d;
    end

    assign snap_o = snap_q;
endmodule

// File: rtl/pxg_table.sv
module pxg_table
    import pxg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [GSEL_W-1:0] wr_grp_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  pte_t              wr_pte_i,
    input  logic [GSEL_W-1:0] rd_grp_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output pte_t              rd_pte_o
);
    pte_t tbl_d [N_GRP][N_ENT];
    pte_t tbl_q [N_GRP][N_ENT];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en_i) tbl_d[wr_grp_i][wr_idx_i] = wr_pte_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int g = 0; g < N_GRP; g++) begin
                for (int e = 0; e < N_ENT; e++) begin
                    tbl_q[g][e].page <= PAGE_W'(e);
                    tbl_q[g][e].lock <= '0;
                end
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_pte_o = tbl_q[rd_grp_i][rd_idx_i];
endmodule

// File: rtl/page_xlate_guard.sv
module page_xlate_guard
    import pxg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [0:15]       addr_data_i,
    input  logic              addr_stb_i,
    input  logic [3:0]        grp_sel_i,
    input  logic [3:0]        key_i,
    input  logic              mem_cycle_i,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_grp_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [7:0]        wr_page_i,
    input  logic [3:0]        wr_lock_i,
    output logic [7:0]        phys_page_o,
    output logic [19:0]       phys_addr_o,
    output logic              prot_err_o
);
    // Bus bit 0 is the MSB; copying into a descending vector keeps that.
    logic [ADDR_W-1:0] bus_msb_first;
    assign bus_msb_first = addr_data_i;

    snap_t snap;
    pte_t  sel_pte;
    pte_t  wr_pte;

    assign wr_pte.page = wr_page_i;
    assign wr_pte.lock = wr_lock_i;

    pxg_capture u_capture (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .stb_i  (addr_stb_i),
        .addr_i (bus_msb_first),
        .grp_i  (grp_sel_i),
        .key_i  (key_i),
        .mem_i  (mem_cycle_i),
        .snap_o (snap)
    );

    pxg_table u_table (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_grp_i (wr_grp_i),
        .wr_idx_i (wr_idx_i),
        .wr_pte_i (wr_pte),
        .rd_grp_i (snap.grp),
        .rd_idx_i (snap.addr[ADDR_W-1 -: IDX_W]),
        .rd_pte_o (sel_pte)
    );

    logic [PHYS_W-1:0] phys;

    always_comb begin
        if (snap.mem) phys = {sel_pte.page, snap.addr[OFF_W-1:0]};
        else          phys = {{EXT_W{1'b0}}, snap.addr};
    end

    assign phys_addr_o = phys;
    assign phys_page_o = phys[PHYS_W-1 -: PAGE_W];
    assign prot_err_o  = snap.valid && snap.mem && (snap.key != sel_pte.lock);
endmodule

// File: rtl/pxg_checker.sv
module pxg_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [0:15] addr_data_i,
    input logic        addr_stb_i,
    input logic        mem_cycle_i,
    input logic        wr_en_i,
    input logic [7:0]  phys_page_o,
    input logic [19:0] phys_addr_o,
    input logic        prot_err_o
);
    a_r3_offset_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(addr_stb_i) |=> phys_addr_o[11:0] == $past(addr_data_i[4:15]));

    a_r6_io_no_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(addr_stb_i) && !mem_cycle_i) |=> !prot_err_o);

    a_r6_io_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(addr_stb_i) && !mem_cycle_i) |=> phys_addr_o[19:16] == 4'h0);

    a_r9_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$fell(addr_stb_i) && !wr_en_i) |=> ($stable(phys_addr_o) && $stable(prot_err_o)));

    a_r5_page_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phys_page_o == phys_addr_o[19:12]);
endmodule

bind page_xlate_guard pxg_checker u_pxg_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_data_i (addr_data_i),
    .addr_stb_i  (addr_stb_i),
    .mem_cycle_i (mem_cycle_i),
    .wr_en_i     (wr_en_i),
    .phys_page_o (phys_page_o),
    .phys_addr_o (phys_addr_o),
    .prot_err_o  (prot_err_o)
);

// File: tb/page_xlate_guard_test.sv
module page_xlate_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:15] bus = '0;
    logic        stb = 1'b0;
    logic [3:0]  grp = '0;
    logic [3:0]  key = '0;
    logic        mem = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  wgrp = '0;
    logic [3:0]  widx = '0;
    logic [7:0]  wpage = '0;
    logic [3:0]  wlock = '0;
    logic [7:0]  page_o;
    logic [19:0] addr_o;
    logic        err_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_page [16][16];
    logic [3:0] m_lock [16][16];

    always #2.5 clk = ~clk;

    page_xlate_guard uut (
        .clk_i(clk), .rst_ni(rst_n), .addr_data_i(bus), .addr_stb_i(stb),
        .grp_sel_i(grp), .key_i(key), .mem_cycle_i(mem), .wr_en_i(we),
        .wr_grp_i(wgrp), .wr_idx_i(widx), .wr_page_i(wpage), .wr_lock_i(wlock),
        .phys_page_o(page_o), .phys_addr_o(addr_o), .prot_err_o(err_o)
    );

    task automatic chk(string req, logic [19:0] ea, logic ee);
        checks++;
        if (addr_o !== ea || err_o !== ee || page_o !== ea[19:12]) begin
            errors++;
            $display("FAIL %s: addr=%h err=%b page=%h expected addr=%h err=%b page=%h",
                     req, addr_o, err_o, page_o, ea, ee, ea[19:12]);
        end
    endtask

    function automatic logic [19:0] exp_addr(logic [15:0] v, logic [3:0] g, logic m);
        return m ? {m_page[g][v[15:12]], v[11:0]} : {4'h0, v};
    endfunction

    function automatic logic exp_err(logic [15:0] v, logic [3:0] g, logic [3:0] k, logic m);
        return m && (k != m_lock[g][v[15:12]]);
    endfunction

    task automatic strobe(logic [15:0] v, logic [3:0] g, logic [3:0] k, logic m);
        @(negedge clk);
        bus = v; grp = g; key = k; mem = m; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        @(negedge clk);
        bus = ~v; grp = ~g; key = ~k; mem = ~m;
    endtask

    task automatic write(logic [3:0] g, logic [3:0] i, logic [7:0] p, logic [3:0] l);
        @(negedge clk);
        we = 1'b1; wgrp = g; widx = i; wpage = p; wlock = l;
        @(negedge clk);
        we = 1'b0;
        m_page[g][i] = p; m_lock[g][i] = l;
    endtask

    task automatic t_reset;
        for (int g = 0; g < 16; g++)
            for (int e = 0; e < 16; e++) begin
                m_page[g][e] = 8'(e); m_lock[g][e] = 4'h0;
            end
        repeat (3) @(negedge clk);
        chk("R1 in reset", 20'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 20'h0, 1'b0);
        strobe(16'h3ABC, 4'd5, 4'h0, 1'b1);
        chk("R1 identity map", 20'h03ABC, 1'b0);
    endtask

    task automatic t_translate;
        write(4'd2, 4'hA, 8'hC7, 4'h9);
        strobe(16'hA123, 4'd2, 4'h9, 1'b1);
        chk("R5 R8 translate", 20'hC7123, 1'b0);
        write(4'd0, 4'h1, 8'hFF, 4'h0);
        strobe(16'h1FFF, 4'd0, 4'h0, 1'b1);
        chk("R5 top page", 20'hFFFFF, 1'b0);
    endtask

    task automatic t_msb;
        strobe(16'h8001, 4'd0, 4'h0, 1'b1);
        chk("R3 bit0 msb", exp_addr(16'h8001, 4'd0, 1'b1), 1'b0);
        strobe(16'h0FFE, 4'd9, 4'h0, 1'b1);
        chk("R3 offset", 20'h00FFE, 1'b0);
    endtask

    task automatic t_group;
        write(4'd7, 4'hA, 8'h11, 4'h3);
        strobe(16'hA555, 4'd7, 4'h3, 1'b1);
        chk("R4 group 7", 20'h11555, 1'b0);
        strobe(16'hA555, 4'd2, 4'h9, 1'b1);
        chk("R4 group 2", 20'hC7555, 1'b0);
    endtask

    task automatic t_keys;
        strobe(16'hA010, 4'd2, 4'h5, 1'b1);
        chk("R7 mismatch", exp_addr(16'hA010, 4'd2, 1'b1), exp_err(16'hA010, 4'd2, 4'h5, 1'b1));
        strobe(16'hA010, 4'd2, 4'h9, 1'b1);
        chk("R7 match", 20'hC7010, 1'b0);
        strobe(16'hA010, 4'd2, 4'h5, 1'b0);
        chk("R6 io cycle", 20'h0A010, 1'b0);
    endtask

    task automatic t_hold;
        strobe(16'hA777, 4'd2, 4'h1, 1'b1);
        chk("R9 held start", 20'hC7777, 1'b1);
        repeat (4) begin
            @(negedge clk);
            bus = $urandom; grp = $urandom; key = $urandom; mem = $urandom;
        end
        chk("R9 held", 20'hC7777, 1'b1);
        @(negedge clk);
        stb = 1'b1; bus = 16'h0123; mem = 1'b0;
        @(negedge clk);
        chk("R2 no capture while high", 20'hC7777, 1'b1);
        stb = 1'b0;
        @(negedge clk);
        chk("R2 capture on fall", 20'h00123, 1'b0);
    endtask

    task automatic t_live_write;
        strobe(16'hA200, 4'd2, 4'h9, 1'b1);
        chk("R8 before write", 20'hC7200, 1'b0);
        write(4'd2, 4'hA, 8'h3C, 4'h6);
        chk("R8 live update", 20'h3C200, 1'b1);
    endtask

    initial begin
        t_reset();
        t_translate();
        t_msb();
        t_group();
        t_keys();
        t_hold();
        t_live_write();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule